// File: doc/BRIEF.md
# Video Output Source Failover Selector

This block sits in a video output path, in front of the stage that inserts sync and blanking. For every active beat requested by a reference raster, it picks the pixel source. The candidates are a primary video stream, an optional secondary stream such as a test pattern, and a constant black pixel. Each stream comes with a lock flag. When the source in use loses lock, the block drops to the next lower source on the following beat without any help from software. A move back up to a healthier source waits for the raster's start-of-frame pulse, so a single frame never mixes two healthy sources.

A small register port gives software control. Software can select the source mode, hold off the automatic return to the primary until it issues a command, force one particular source, and replace the black pixel value. A read-only status word reports the source in use and both lock flags. Every beat carries a parameterised number of pixels, and one selection covers the whole beat. Alignment of pixels to the raster, timing generation and blanking are handled by other blocks.

Top module: `vid_src_failover`

## Requirements
- R1: A beat requested by `ref_act` in cycle t appears in cycle t+1: `out_valid` is set and all PIX_PER_BEAT pixels of `out_data` come from the same source. When `ref_act` is low, `out_valid` is low in the following cycle.
- R2: In auto mode (control bits [1:0] = 0), if the primary is in use and `pri_lock` is low in a cycle that is not a start of frame, the next beat uses the secondary when `sec_lock` is high.
- R3: In auto mode, a source that fails outside a start of frame is left for black on the next beat in two cases: the primary fails and the secondary is unlocked, or the secondary fails while in use. With HAS_SECONDARY = 0 the secondary is never chosen.
- R4: The black pixel resets to BLACK_INIT. Software can write it at address 1 and read it back there. Each black beat repeats it in every pixel lane.
- R5: In auto mode, a return from secondary or black to primary happens only at the cycle after a `ref_sof` pulse, and a mid-frame relock has no effect before that point.
- R6: In auto mode, a move from black up to the secondary also happens only at a start of frame.
- R7: With control bit 2 set, a relocked primary is not taken back. Writing control bit 3 = 1 arms a return, which takes place at the next start of frame with the primary locked. The armed request clears once the primary is in use. Control reads back bits [3:0].
- R8: Control bits [1:0] = 1, 2 or 3 force primary, secondary or black. The forced source is taken at the next start of frame, whatever the lock flags.
- R9: Address 2 reads the status word: bits [1:0] give the source in use (0 primary, 1 secondary, 2 black), bit 4 gives `pri_lock`, bit 5 gives `sec_lock`, and the other bits read 0.
- R10: `pri_ready` is high in every cycle in which the primary is not in use, so primary beats are taken and dropped. `sec_ready` is high only when the secondary is in use and `ref_act` is high.
- R11: If the source in use has no valid beat when `ref_act` is high, that output beat is black.
- R12: After reset the source is black, `out_valid` is low and the control register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_sof | input | 1 | One-cycle start-of-frame pulse from the reference raster |
| ref_act | input | 1 | Reference raster requests an active beat this cycle |
| pri_valid | input | 1 | Primary beat present |
| pri_data | input | PIX_PER_BEAT*PIX_W | Primary pixels, lane 0 in the low bits |
| pri_ready | output | 1 | Primary beat taken |
| pri_lock | input | 1 | Primary locked to the raster |
| sec_valid | input | 1 | Secondary beat present |
| sec_data | input | PIX_PER_BEAT*PIX_W | Secondary pixels |
| sec_ready | output | 1 | Secondary beat taken |
| sec_lock | input | 1 | Secondary healthy |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 control, 1 black, 2 status |
| cfg_wdata | input | PIX_W | Register write data |
| cfg_rdata | output | PIX_W | Register read data for `cfg_addr` |
| out_valid | output | 1 | Output beat present |
| out_data | output | PIX_PER_BEAT*PIX_W | Output pixels |

## Verification
The assertions check on every cycle that the selection never moves up between frames, that a failed source is left on the following beat, that the handshakes follow the selection, that the status code stays legal, and that black beats carry the black register. The bench's scenarios are needed for the rest. They show that the manual-return command and the forced modes take effect at the right frame boundary, that a new black value reaches the output and reads back, and that a primary beat missing during an active cycle turns into black.

// File: rtl/vsf_pkg.sv
package vsf_pkg;
   typedef enum logic [1:0] {
      SRC_PRI = 2'd0,
      SRC_SEC = 2'd1,
      SRC_BLK = 2'd2
   } src_e;

   localparam logic [1:0] MODE_AUTO  = 2'd0;
   localparam logic [1:0] FORCE_PRI  = 2'd1;
   localparam logic [1:0] FORCE_SEC  = 2'd2;
   localparam logic [1:0] FORCE_BLK  = 2'd3;

   localparam logic [1:0] ADDR_CTRL  = 2'd0;
   localparam logic [1:0] ADDR_BLACK = 2'd1;
   localparam logic [1:0] ADDR_STAT  = 2'd2;
endpackage

// File: rtl/vsf_regs.sv
module vsf_regs
   import vsf_pkg::*;
#(
   parameter int unsigned PIX_W      = 8,
   parameter logic [PIX_W-1:0] BLACK_INIT = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [1:0]       addr,
   input  logic [PIX_W-1:0] wdata,
   output logic [PIX_W-1:0] rdata,
   input  src_e             cur_src,
   input  logic             pri_lock,
   input  logic             sec_lock,
   output logic [1:0]       mode,
   output logic             man_ret,
   output logic             ret_pend,
   output logic [PIX_W-1:0] black
);
   logic ctrl_wr;
   logic unused_wbits;

   assign ctrl_wr      = we && (addr == ADDR_CTRL);
   assign unused_wbits = ^wdata[PIX_W-1:4];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode     <= MODE_AUTO;
         man_ret  <= 1'b0;
         ret_pend <= 1'b0;
         black    <= BLACK_INIT;
      end else begin
         if (ctrl_wr) begin
            mode    <= wdata[1:0];
            man_ret <= wdata[2];
         end
         if (ctrl_wr && wdata[3])
            ret_pend <= 1'b1;
         else if (cur_src == SRC_PRI)
            ret_pend <= 1'b0;
         if (we && (addr == ADDR_BLACK))
            black <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      case (addr)
         ADDR_CTRL:  rdata[3:0] = {ret_pend, man_ret, mode};
         ADDR_BLACK: rdata = black;
         ADDR_STAT:  rdata[5:0] = {sec_lock, pri_lock, 2'b00, cur_src};
         default:    rdata = '0;
      endcase
   end
endmodule

// File: rtl/vsf_sel.sv
module vsf_sel
   import vsf_pkg::*;
#(
   parameter bit HAS_SECONDARY = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sof,
   input  logic       pri_lock,
   input  logic       sec_lock,
   input  logic [1:0] mode,
   input  logic       man_ret,
   input  logic       ret_pend,
   output src_e       cur_src
);
   logic sec_ok;
   logic pri_allowed;
   src_e nxt;

   assign sec_ok      = HAS_SECONDARY && sec_lock;
   assign pri_allowed = pri_lock && ((cur_src == SRC_PRI) || !man_ret || ret_pend);

   always_comb begin
      nxt = cur_src;
      if (mode != MODE_AUTO) begin
         if (sof) begin
            case (mode)
               FORCE_PRI: nxt = SRC_PRI;
               FORCE_SEC: nxt = HAS_SECONDARY ? SRC_SEC : SRC_BLK;
               default:   nxt = SRC_BLK;
            endcase
         end
      end else if (sof) begin
         if (pri_allowed)  nxt = SRC_PRI;
         else if (sec_ok)  nxt = SRC_SEC;
         else              nxt = SRC_BLK;
      end else if ((cur_src == SRC_PRI) && !pri_lock) begin
         nxt = sec_ok ? SRC_SEC : SRC_BLK;
      end else if ((cur_src == SRC_SEC) && !sec_ok) begin
         nxt = SRC_BLK;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) cur_src <= SRC_BLK;
      else        cur_src <= nxt;
   end
endmodule

// File: rtl/vsf_pix_mux.sv
module vsf_pix_mux
   import vsf_pkg::*;
#(
   parameter int unsigned PIX_PER_BEAT = 4,
   parameter int unsigned PIX_W        = 8,
   localparam int unsigned BEAT_W      = PIX_PER_BEAT * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act,
   input  src_e              cur_src,
   input  logic              pri_valid,
   input  logic [BEAT_W-1:0] pri_data,
   input  logic              sec_valid,
   input  logic [BEAT_W-1:0] sec_data,
   input  logic [PIX_W-1:0]  black,
   output logic              out_valid,
   output logic [BEAT_W-1:0] out_data
);
   logic take_pri;
   logic take_sec;

   assign take_pri = (cur_src == SRC_PRI) && pri_valid;
   assign take_sec = (cur_src == SRC_SEC) && sec_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= act;
   end

   for (genvar i = 0; i < PIX_PER_BEAT; i++) begin : g_lane
      logic [PIX_W-1:0] lane_nxt;
      always_comb begin
         if (take_pri)      lane_nxt = pri_data[i*PIX_W +: PIX_W];
         else if (take_sec) lane_nxt = sec_data[i*PIX_W +: PIX_W];
         else               lane_nxt = black;
      end
      always_ff @(posedge clk) begin
         if (!rst_n)   out_data[i*PIX_W +: PIX_W] <= '0;
         else if (act) out_data[i*PIX_W +: PIX_W] <= lane_nxt;
      end
   end
endmodule

// File: rtl/vid_src_failover.sv
module vid_src_failover
   import vsf_pkg::*;
#(
   parameter int unsigned PIX_PER_BEAT  = 4,
   parameter int unsigned PIX_W         = 8,
   parameter bit          HAS_SECONDARY = 1'b1,
   parameter logic [PIX_W-1:0] BLACK_INIT = '0,
   localparam int unsigned BEAT_W       = PIX_PER_BEAT * PIX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_sof,
   input  logic              ref_act,
   input  logic              pri_valid,
   input  logic [BEAT_W-1:0] pri_data,
   output logic              pri_ready,
   input  logic              pri_lock,
   input  logic              sec_valid,
   input  logic [BEAT_W-1:0] sec_data,
   output logic              sec_ready,
   input  logic              sec_lock,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_addr,
   input  logic [PIX_W-1:0]  cfg_wdata,
   output logic [PIX_W-1:0]  cfg_rdata,
   output logic              out_valid,
   output logic [BEAT_W-1:0] out_data
);
   if (PIX_PER_BEAT < 1 || PIX_PER_BEAT > 8) begin : g_bad_ppb
      $error("PIX_PER_BEAT must lie in 1..8");
   end
   if (PIX_W < 8) begin : g_bad_pixw
      $error("PIX_W must be at least 8 to hold the status word");
   end

   src_e             cur_src;
   logic [1:0]       ctrl_mode;
   logic             man_ret;
   logic             ret_pend;
   logic [PIX_W-1:0] black_px;
   logic             sec_valid_g;
   logic             sec_lock_g;

   if (HAS_SECONDARY) begin : g_sec
      assign sec_valid_g = sec_valid;
      assign sec_lock_g  = sec_lock;
      assign sec_ready   = ref_act && (cur_src == SRC_SEC);
   end else begin : g_nosec
      logic unused_sec;
      assign unused_sec  = sec_valid ^ sec_lock ^ (^sec_data);
      assign sec_valid_g = 1'b0;
      assign sec_lock_g  = 1'b0;
      assign sec_ready   = 1'b0;
   end

   assign pri_ready = (cur_src != SRC_PRI) || ref_act;

   vsf_regs #(.PIX_W(PIX_W), .BLACK_INIT(BLACK_INIT)) u_regs (
      .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
      .wdata(cfg_wdata), .rdata(cfg_rdata), .cur_src(cur_src),
      .pri_lock(pri_lock), .sec_lock(sec_lock_g), .mode(ctrl_mode),
      .man_ret(man_ret), .ret_pend(ret_pend), .black(black_px)
   );

   vsf_sel #(.HAS_SECONDARY(HAS_SECONDARY)) u_sel (
      .clk(clk), .rst_n(rst_n), .sof(ref_sof), .pri_lock(pri_lock),
      .sec_lock(sec_lock_g), .mode(ctrl_mode), .man_ret(man_ret),
      .ret_pend(ret_pend), .cur_src(cur_src)
   );

   vsf_pix_mux #(.PIX_PER_BEAT(PIX_PER_BEAT), .PIX_W(PIX_W)) u_mux (
      .clk(clk), .rst_n(rst_n), .act(ref_act), .cur_src(cur_src),
      .pri_valid(pri_valid), .pri_data(pri_data),
      .sec_valid(sec_valid_g), .sec_data(sec_data),
      .black(black_px), .out_valid(out_valid), .out_data(out_data)
   );
endmodule

// File: rtl/vsf_checker.sv
module vsf_checker #(
   parameter int unsigned PIX_PER_BEAT = 4,
   parameter int unsigned PIX_W        = 8,
   localparam int unsigned BEAT_W      = PIX_PER_BEAT * PIX_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic              sof,
   input logic              act,
   input logic              pri_lock,
   input logic              sec_lock,
   input logic              pri_ready,
   input logic              sec_ready,
   input logic              out_valid,
   input logic [BEAT_W-1:0] out_data,
   input logic [1:0]        cur_src,
   input logic [1:0]        mode,
   input logic [PIX_W-1:0]  black
);
   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      act |=> out_valid);                                                   // R1
   AST_IDLE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      !act |=> !out_valid);                                                 // R1
   AST_PRI_FAIL_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !sof && cur_src == 2'd0 && !pri_lock) |=> cur_src != 2'd0); // R2
   AST_SEC_FAIL_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'd0 && !sof && cur_src == 2'd1 && !sec_lock) |=> cur_src == 2'd2); // R3
   AST_BLACK_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (act && cur_src == 2'd2) |=> out_data == {PIX_PER_BEAT{$past(black)}}); // R4
   AST_NO_MIDFRAME_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof && cur_src != 2'd0) |=> cur_src != 2'd0);                       // R5
   AST_NO_MIDFRAME_UPGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (!sof && cur_src == 2'd2) |=> cur_src == 2'd2);                       // R6
   AST_SRC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      cur_src != 2'd3);                                                     // R9
   AST_PRI_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_src != 2'd0) |-> pri_ready);                                     // R10
   AST_SEC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !(act && cur_src == 2'd1) |-> !sec_ready);                            // R10
endmodule

bind vid_src_failover vsf_checker #(.PIX_PER_BEAT(PIX_PER_BEAT), .PIX_W(PIX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sof(ref_sof), .act(ref_act),
   .pri_lock(pri_lock), .sec_lock(sec_lock_g), .pri_ready(pri_ready),
   .sec_ready(sec_ready), .out_valid(out_valid), .out_data(out_data),
   .cur_src(cur_src), .mode(ctrl_mode), .black(black_px)
);

// File: tb/vid_src_failover_tb.sv
module vid_src_failover_tb;
   localparam int CLK_PERIOD = 10;
   localparam int N     = 4;
   localparam int W     = 8;
   localparam int BW    = N * W;
   localparam int FRAME = 12;
   localparam logic [W-1:0] BLK_INIT = 8'h10;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ref_sof = 1'b0, ref_act = 1'b0;
   logic pri_valid = 1'b1, pri_lock = 1'b0;
   logic [BW-1:0] pri_data = '0;
   logic sec_valid = 1'b1, sec_lock = 1'b0;
   logic [BW-1:0] sec_data = 32'hA3A2A1A0;
   logic cfg_we = 1'b0;
   logic [1:0] cfg_addr = 2'd2;
   logic [W-1:0] cfg_wdata = '0;
   logic [W-1:0] cfg_rdata;
   logic pri_ready, sec_ready, out_valid;
   logic [BW-1:0] out_data;

   int checks = 0;
   int bad = 0;
   int fcnt = 0;
   int pcnt = 0;
   bit done = 1'b0;
   string phase = "R12";

   // behavioural reference state
   int m_cur = 2;
   int m_mode = 0;
   bit m_man = 0, m_pend = 0;
   logic [W-1:0] m_black = BLK_INIT;
   bit m_oval = 0;
   logic [BW-1:0] m_odata = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   vid_src_failover #(.PIX_PER_BEAT(N), .PIX_W(W), .HAS_SECONDARY(1'b1),
                      .BLACK_INIT(BLK_INIT)) u_dut (
      .clk(clk), .rst_n(rst_n), .ref_sof(ref_sof), .ref_act(ref_act),
      .pri_valid(pri_valid), .pri_data(pri_data), .pri_ready(pri_ready),
      .pri_lock(pri_lock), .sec_valid(sec_valid), .sec_data(sec_data),
      .sec_ready(sec_ready), .sec_lock(sec_lock), .cfg_we(cfg_we),
      .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .out_valid(out_valid), .out_data(out_data)
   );

   always @(posedge clk) begin
      int old_cur;
      bit set_pend;
      if (!rst_n) begin
         m_cur = 2; m_mode = 0; m_man = 0; m_pend = 0;
         m_black = BLK_INIT; m_oval = 0; m_odata = '0;
      end else begin
         old_cur = m_cur;
         m_oval = ref_act;
         if (ref_act) begin
            if (old_cur == 0 && pri_valid)      m_odata = pri_data;
            else if (old_cur == 1 && sec_valid) m_odata = sec_data;
            else                                m_odata = {N{m_black}};
         end
         if (m_mode != 0) begin
            if (ref_sof) m_cur = (m_mode == 1) ? 0 : (m_mode == 2) ? 1 : 2;
         end else if (ref_sof) begin
            if (pri_lock && (old_cur == 0 || !m_man || m_pend)) m_cur = 0;
            else if (sec_lock) m_cur = 1;
            else m_cur = 2;
         end else if (old_cur == 0 && !pri_lock) begin
            m_cur = sec_lock ? 1 : 2;
         end else if (old_cur == 1 && !sec_lock) begin
            m_cur = 2;
         end
         set_pend = cfg_we && cfg_addr == 2'd0 && cfg_wdata[3];
         if (set_pend) m_pend = 1;
         else if (old_cur == 0) m_pend = 0;
         if (cfg_we && cfg_addr == 2'd0) begin
            m_mode = int'(cfg_wdata[1:0]);
            m_man  = cfg_wdata[2];
         end
         if (cfg_we && cfg_addr == 2'd1) m_black = cfg_wdata;
      end
      if (pri_valid && pri_ready) pcnt++;
   end

   task automatic chk(input bit ok, input string tag, input logic [31:0] act_v,
                      input logic [31:0] exp_v);
      checks++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
      end
   endtask

   task automatic tick();
      logic [W-1:0] st;
      @(negedge clk);
      if (rst_n) begin
         chk(out_valid == m_oval, {phase, " out_valid"}, 32'(out_valid), 32'(m_oval));
         if (m_oval) chk(out_data == m_odata, {phase, " out_data"}, out_data, m_odata);
         if (cfg_addr == 2'd2) begin
            st = {2'b00, sec_lock, pri_lock, 2'b00, 2'(m_cur)};
            chk(cfg_rdata == st, {phase, " status R9"}, 32'(cfg_rdata), 32'(st));
         end
      end
      cfg_we = 1'b0;
      cfg_addr = 2'd2;
      fcnt = (fcnt + 1) % FRAME;
      ref_sof = (fcnt == 0);
      ref_act = (fcnt >= 2 && fcnt <= 9);
      for (int i = 0; i < N; i++) pri_data[i*W +: W] = W'(pcnt * N + i);
      #1;
      if (rst_n) begin
         chk(pri_ready == (m_cur != 0 || ref_act), {phase, " pri_ready R10"},
             32'(pri_ready), 32'(m_cur != 0 || ref_act));
         chk(sec_ready == (m_cur == 1 && ref_act), {phase, " sec_ready R10"},
             32'(sec_ready), 32'(m_cur == 1 && ref_act));
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      tick();
   endtask

   task automatic run_to_sof();
      do tick(); while (!ref_sof);
   endtask

   task automatic chk_src(input int e, input string tag);
      chk(cfg_rdata[1:0] == 2'(e), tag, 32'(cfg_rdata[1:0]), 32'(e));
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R12 reset state
      chk(out_valid == 1'b0, "R12 out_valid in reset", 32'(out_valid), 0);
      chk_src(2, "R12 source black in reset");
      cfg_addr = 2'd0; #1;
      chk(cfg_rdata == '0, "R12 control zero", 32'(cfg_rdata), 0);
      cfg_addr = 2'd1; #1;
      chk(cfg_rdata == BLK_INIT, "R4 black default", 32'(cfg_rdata), 32'(BLK_INIT));
      cfg_addr = 2'd2;
      rst_n = 1'b1;
      pri_lock = 1'b1; sec_lock = 1'b1;

      phase = "R1";
      run_to_sof(); tick();
      chk_src(0, "R1 primary picked at frame start");
      repeat (2 * FRAME) tick();

      phase = "R2";
      run_to_sof(); repeat (4) tick();
      pri_lock = 1'b0; tick();
      chk_src(1, "R2 secondary on next beat");
      repeat (2) tick();

      phase = "R5";
      pri_lock = 1'b1; repeat (2) tick();
      chk_src(1, "R5 no mid-frame return");
      run_to_sof();
      chk_src(1, "R5 still secondary before edge");
      tick();
      chk_src(0, "R5 primary after frame start");

      phase = "R3";
      repeat (3) tick();
      sec_lock = 1'b0; pri_lock = 1'b0; tick();
      chk_src(2, "R3 black when both lost");
      run_to_sof(); tick();
      pri_lock = 1'b1; sec_lock = 1'b1; run_to_sof();
      // move to secondary-only and then lose it
      pri_lock = 1'b0; tick();
      chk_src(1, "R3 secondary at frame start");
      sec_lock = 1'b0; tick();
      chk_src(2, "R3 failed secondary goes black");

      phase = "R6";
      sec_lock = 1'b1; repeat (3) tick();
      chk_src(2, "R6 no mid-frame upgrade");
      run_to_sof(); tick();
      chk_src(1, "R6 secondary after frame start");
      run_to_sof();
      phase = "R4";
      wr(2'd1, 8'h3C);
      cfg_addr = 2'd1; #1;
      chk(cfg_rdata == 8'h3C, "R4 black readback", 32'(cfg_rdata), 32'h3C);
      cfg_addr = 2'd2;
      sec_lock = 1'b0; repeat (FRAME) tick();
      chk_src(2, "R4 black in use");

      phase = "R7";
      pri_lock = 1'b1; sec_lock = 1'b1;
      run_to_sof(); tick();
      chk_src(0, "R7 primary restored");
      wr(2'd0, 8'h04);
      pri_lock = 1'b0; tick();
      chk_src(1, "R7 failover still automatic");
      pri_lock = 1'b1;
      run_to_sof(); tick();
      chk_src(1, "R7 held after first frame");
      run_to_sof(); tick();
      chk_src(1, "R7 held after second frame");
      wr(2'd0, 8'h0C);
      cfg_addr = 2'd0; #1;
      chk(cfg_rdata == 8'h0C, "R7 control readback", 32'(cfg_rdata), 32'h0C);
      cfg_addr = 2'd2;
      run_to_sof(); tick();
      chk_src(0, "R7 return on command");
      tick();
      cfg_addr = 2'd0; #1;
      chk(cfg_rdata == 8'h04, "R7 request cleared", 32'(cfg_rdata), 32'h04);
      cfg_addr = 2'd2;

      phase = "R8";
      wr(2'd0, 8'h03); tick();
      chk_src(0, "R8 force waits for frame");
      run_to_sof(); tick();
      chk_src(3'd2, "R8 forced black");
      pri_lock = 1'b0; sec_lock = 1'b0;
      wr(2'd0, 8'h02); run_to_sof(); tick();
      chk_src(1, "R8 forced secondary unlocked");
      wr(2'd0, 8'h01); run_to_sof(); tick();
      chk_src(0, "R8 forced primary unlocked");
      repeat (3) tick();
      chk_src(0, "R8 force holds despite lock");
      pri_lock = 1'b1; sec_lock = 1'b1;
      wr(2'd0, 8'h00);

      phase = "R11";
      run_to_sof(); tick();
      chk_src(0, "R11 primary in use");
      pri_valid = 1'b0;
      repeat (FRAME) tick();
      pri_valid = 1'b1;
      repeat (FRAME) tick();

      phase = "R10";
      pri_lock = 1'b0; tick();
      chk(pri_ready == 1'b1, "R10 primary drained", 32'(pri_ready), 1);
      repeat (2 * FRAME) tick();
      tick();

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; bad++;
         $display("FAIL watchdog expired in phase %s actual=0 expected=1", phase);
         $display("  test done: total=%0d bad=%0d", checks, bad);
         $finish;
      end
   end
endmodule